// File: doc/BRIEF.md
# Multi-Pipe Receive Address Matcher

This block decides which of six receive pipes, if any, a packet was sent to. The receiver passes the destination address of each incoming packet to the matcher one byte at a time, least significant byte first. A start strobe marks the first byte. The matcher keeps a running hit vector with one bit per pipe. Each new byte clears the bit of every pipe whose expected byte differs from it.

Pipe 0 has a complete address of its own, up to five bytes. Pipes 1 to 5 differ from one another only in their least significant byte. All their higher bytes come from one shared register.

The comparison ends when the configured number of address bytes (3, 4 or 5) has arrived. At that point the per-pipe enable mask is applied and the lowest-numbered surviving pipe is chosen. A match flag and a 3-bit pipe number are then registered. The pipe number is sized to drop straight into bits 3:1 of a status word. When nothing matches, that field reads 3'b111.

Top module: `rx_pipe_addr_match`

## Requirements
- R1: Pipe 0 matches only when every received address byte i equals byte i of `pipe0_addr_i`, where byte i is bits 8i+7:8i.
- R2: For pipes 1 to 5, byte 0 is compared with that pipe's own low byte, held in `pipe_lsb_i` bits 8(k-1)+7:8(k-1) for pipe k. Each later byte i is compared with byte i-1 of `shared_hi_i`.
- R3: `aw_sel_i` sets the address length: 2'b10 means 4 bytes, 2'b11 means 5 bytes, and 2'b01 or 2'b00 means 3 bytes. Register bytes above the configured length are never compared.
- R4: Bytes are taken only while `byte_valid_i` is high. A byte with `start_i` high always begins a new address, even in the middle of one. A valid byte without `start_i` while no address is in progress is ignored. Idle cycles between the bytes of one address are allowed.
- R5: A pipe whose bit in `pipe_en_i` is clear never matches. The mask is sampled in the cycle of the last address byte.
- R6: When several enabled pipes match, the lowest-numbered one is reported.
- R7: When no enabled pipe matches, `match_o` is 0 and `pipe_num_o` is 3'b111.
- R8: `done_o` is high for exactly one cycle, the cycle after the last address byte is accepted. `match_o` and `pipe_num_o` change only then and hold their values until the next completion. After reset `done_o` is 0, `match_o` is 0 and `pipe_num_o` is 3'b111.
- R9: On a match, `pipe_num_o` carries the binary pipe number 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks the first (least significant) address byte |
| byte_valid_i | input | 1 | Address byte on `byte_i` is valid |
| byte_i | input | 8 | Received address byte |
| pipe_en_i | input | 6 | Per-pipe enable mask, bit k for pipe k |
| aw_sel_i | input | 2 | Address length code |
| pipe0_addr_i | input | 40 | Full address of pipe 0 |
| shared_hi_i | input | 32 | Upper four address bytes shared by pipes 1 to 5 |
| pipe_lsb_i | input | 40 | Low address byte of pipes 1 to 5 |
| done_o | output | 1 | One-cycle completion pulse |
| match_o | output | 1 | An enabled pipe matched |
| pipe_num_o | output | 3 | Matching pipe number, 3'b111 when none |

## Verification
Random frames are built from a randomly chosen pipe's reference address, so matches land on every pipe at every address length. Random bytes from the same frames show that near misses are rejected. Directed frames then isolate each corner case:
- bits placed only above the configured length show that those bits are really ignored;
- two pipes given the same low byte, and pipe 0 given the shared pattern, expose the priority order;
- a cleared mask bit on a matching pipe shows that the mask is applied;
- a second start strobe in mid-address, stray bytes outside an address, and gaps inside one separate correct framing from a plain byte counter.

// File: rtl/rx_match_pkg.sv
package rx_match_pkg;
    localparam int NPIPE     = 6;
    localparam int MAX_BYTES = 5;
    localparam int IDX_W     = $clog2(MAX_BYTES + 1);
    typedef logic [2:0] pipe_num_t;
    localparam pipe_num_t PIPE_NONE = 3'b111;
endpackage

// File: rtl/rx_match_ref_sel.sv
module rx_match_ref_sel
    import rx_match_pkg::*;
#(
    parameter int NP = NPIPE,
    parameter int MB = MAX_BYTES,
    localparam int IW = $clog2(MB + 1)
) (
    input  logic [IW-1:0]        idx_i,
    input  logic [7:0]           rx_byte_i,
    input  logic [8*MB-1:0]      pipe0_addr_i,
    input  logic [8*(MB-1)-1:0]  shared_hi_i,
    input  logic [8*(NP-1)-1:0]  pipe_lsb_i,
    output logic [NP-1:0]        eq_o
);
    logic [7:0] exp_byte [NP];

    for (genvar p = 0; p < NP; p++) begin : g_pipe
        if (p == 0) begin : g_full
            always_comb begin
                int k;
                k = int'(idx_i);
                if (k > MB - 1) k = MB - 1;
                exp_byte[p] = pipe0_addr_i[k*8 +: 8];
            end
        end else begin : g_shared
            always_comb begin
                int k;
                k = int'(idx_i);
                if (k > MB - 1) k = MB - 1;
                if (k == 0) exp_byte[p] = pipe_lsb_i[(p-1)*8 +: 8];
                else        exp_byte[p] = shared_hi_i[(k-1)*8 +: 8];
            end
        end
        assign eq_o[p] = (exp_byte[p] == rx_byte_i);
    end
endmodule

// File: rtl/rx_match_prio.sv
module rx_match_prio
    import rx_match_pkg::*;
#(
    parameter int NP = NPIPE
) (
    input  logic [NP-1:0] hit_i,
    output logic          found_o,
    output pipe_num_t     pnum_o
);
    always_comb begin
        found_o = 1'b0;
        pnum_o  = PIPE_NONE;
        for (int p = NP - 1; p >= 0; p--) begin
            if (hit_i[p]) begin
                found_o = 1'b1;
                pnum_o  = pipe_num_t'(p);
            end
        end
    end

    // R6: no lower-numbered pipe may hit when a pipe is reported
    always_comb begin
        if (found_o) begin
            assert_lowest_wins_R6: assert ((hit_i & ((NP'(1) << pnum_o) - NP'(1))) == '0);
        end
    end
endmodule

// File: rtl/rx_pipe_addr_match.sv
module rx_pipe_addr_match
    import rx_match_pkg::*;
#(
    parameter int NP = NPIPE,
    parameter int MB = MAX_BYTES,
    localparam int IW = $clog2(MB + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 byte_valid_i,
    input  logic [7:0]           byte_i,
    input  logic [NP-1:0]        pipe_en_i,
    input  logic [1:0]           aw_sel_i,
    input  logic [8*MB-1:0]      pipe0_addr_i,
    input  logic [8*(MB-1)-1:0]  shared_hi_i,
    input  logic [8*(NP-1)-1:0]  pipe_lsb_i,
    output logic                 done_o,
    output logic                 match_o,
    output logic [2:0]           pipe_num_o
);
    typedef struct packed {
        logic          active;
        logic [IW-1:0] idx;
        logic [NP-1:0] hit;
        logic          done;
        logic          match;
        pipe_num_t     pnum;
    } state_t;

    state_t q, d;

    logic [IW-1:0] aw_bytes;
    logic [IW-1:0] cur_idx;
    logic [IW-1:0] nxt_idx;
    logic [NP-1:0] eq_w;
    logic [NP-1:0] hit_now;
    logic          found_w;
    pipe_num_t     pnum_w;

    always_comb begin
        case (aw_sel_i)
            2'b10:   aw_bytes = IW'(4);
            2'b11:   aw_bytes = IW'(5);
            default: aw_bytes = IW'(3);
        endcase
    end

    assign cur_idx = start_i ? '0 : q.idx;
    assign nxt_idx = cur_idx + 1'b1;
    assign hit_now = start_i ? eq_w : (q.hit & eq_w);

    rx_match_ref_sel #(.NP(NP), .MB(MB)) u_ref (
        .idx_i        (cur_idx),
        .rx_byte_i    (byte_i),
        .pipe0_addr_i (pipe0_addr_i),
        .shared_hi_i  (shared_hi_i),
        .pipe_lsb_i   (pipe_lsb_i),
        .eq_o         (eq_w)
    );

    rx_match_prio #(.NP(NP)) u_prio (
        .hit_i   (hit_now & pipe_en_i),
        .found_o (found_w),
        .pnum_o  (pnum_w)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (byte_valid_i && (start_i || q.active)) begin
            d.hit    = hit_now;
            d.idx    = nxt_idx;
            d.active = 1'b1;
            if (nxt_idx >= aw_bytes) begin
                d.active = 1'b0;
                d.done   = 1'b1;
                d.match  = found_w;
                d.pnum   = pnum_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.active <= 1'b0;
            q.idx    <= '0;
            q.hit    <= '0;
            q.done   <= 1'b0;
            q.match  <= 1'b0;
            q.pnum   <= PIPE_NONE;
        end else begin
            q <= d;
        end
    end

    assign done_o     = q.done;
    assign match_o    = q.match;
    assign pipe_num_o = q.pnum;

    assert_none_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !q.match |-> q.pnum == PIPE_NONE);
    assert_pipe_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.match |-> int'(q.pnum) < NP);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> ($stable(q.match) && $stable(q.pnum)));
    assert_enabled_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.match) |-> |($past(pipe_en_i) & (NP'(1) << q.pnum)));
    assert_idle_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.active && !start_i) |=> !q.done);
endmodule

// File: tb/rx_pipe_addr_match_test.sv
module rx_pipe_addr_match_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [5:0]  pipe_en_i = '1;
    logic [1:0]  aw_sel_i = 2'b11;
    logic [39:0] pipe0_addr_i = '0;
    logic [31:0] shared_hi_i = '0;
    logic [39:0] pipe_lsb_i = '0;
    logic        done_o, match_o;
    logic [2:0]  pipe_num_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_pipe_addr_match uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .pipe_en_i(pipe_en_i), .aw_sel_i(aw_sel_i),
        .pipe0_addr_i(pipe0_addr_i), .shared_hi_i(shared_hi_i), .pipe_lsb_i(pipe_lsb_i),
        .done_o(done_o), .match_o(match_o), .pipe_num_o(pipe_num_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nbytes_of(input logic [1:0] code);
        return (code == 2'b10) ? 4 : (code == 2'b11) ? 5 : 3;
    endfunction

    function automatic logic [39:0] ref_of(input int p);
        if (p == 0) return pipe0_addr_i;
        return {shared_hi_i, pipe_lsb_i[(p-1)*8 +: 8]};
    endfunction

    function automatic int exp_pipe(input logic [39:0] a);
        int n = nbytes_of(aw_sel_i);
        logic [39:0] mask = (40'd1 << (8*n)) - 40'd1;
        for (int p = 0; p < 6; p++)
            if (pipe_en_i[p] && ((ref_of(p) & mask) == (a & mask))) return p;
        return 7;
    endfunction

    task automatic send(input logic [39:0] a, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            start_i = (i == 0);
            byte_valid_i = 1'b1;
            byte_i = a[i*8 +: 8];
            @(negedge clk);
            start_i = 1'b0;
            byte_valid_i = 1'b0;
            if (i != n - 1) repeat (gap) @(negedge clk);
        end
    endtask

    task automatic frame_check(input string req, input logic [39:0] a, input int gap);
        int e = exp_pipe(a);
        send(a, nbytes_of(aw_sel_i), gap);
        chk({req, " done"}, done_o, 1);
        chk({req, " match"}, match_o, (e != 7) ? 1 : 0);
        chk({req, " pipe"}, pipe_num_o, e);
        @(negedge clk);
        chk({req, " pulse"}, done_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        pipe0_addr_i = 40'h0110_4334_77;
        shared_hi_i  = 32'hC2C2_C2C2;
        pipe_lsb_i   = 40'hC5C4_C3C2_C1;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset done", done_o, 0);
        chk("R8 reset match", match_o, 0);
        chk("R8 reset pipe", pipe_num_o, 7);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 pipe 0 full address
        aw_sel_i = 2'b11; pipe_en_i = '1;
        frame_check("R1", pipe0_addr_i, 0);
        // R1 last byte differs
        frame_check("R1 miss", pipe0_addr_i ^ 40'h80_0000_0000, 0);
        // R2 pipe 3 at 4 bytes
        aw_sel_i = 2'b10;
        frame_check("R2", ref_of(3), 0);
        chk("R9 pipe3", pipe_num_o, 3);
        // R3 3-byte width: upper register bytes ignored
        aw_sel_i = 2'b01;
        send({16'h0, pipe0_addr_i[23:0] }, 3, 0);
        chk("R3 width3 match", match_o, 1);
        chk("R3 width3 pipe", pipe_num_o, 0);
        @(negedge clk);
        aw_sel_i = 2'b00;
        frame_check("R3 code00", {16'hDEAD, 8'hC2, 8'hC2, 8'hC5}, 0);
        // R5 disabled matching pipe
        aw_sel_i = 2'b11; pipe_en_i = 6'b110111;
        frame_check("R5", ref_of(3), 0);
        chk("R7 none pipe", pipe_num_o, 7);
        chk("R7 none match", match_o, 0);
        pipe_en_i = '1;
        // R6 priority: pipes 2 and 4 share low byte
        pipe_lsb_i[8 +: 8] = 8'hAA; pipe_lsb_i[24 +: 8] = 8'hAA;
        frame_check("R6 two", ref_of(2), 0);
        chk("R6 lowest", pipe_num_o, 2);
        pipe0_addr_i = ref_of(1);
        frame_check("R6 zero", ref_of(1), 0);
        chk("R6 pipe0 wins", pipe_num_o, 0);
        pipe0_addr_i = 40'h0110_4334_77;
        // R4 restart mid-address, stray bytes, gaps
        send(40'h1122334455, 2, 0);
        frame_check("R4 restart", ref_of(5), 0);
        chk("R4 restart pipe", pipe_num_o, 5);
        byte_valid_i = 1'b1; byte_i = 8'h77;
        repeat (6) @(negedge clk);
        byte_valid_i = 1'b0;
        chk("R4 stray done", done_o, 0);
        chk("R8 hold pipe", pipe_num_o, 5);
        frame_check("R4 gaps", ref_of(4), 3);

        // random frames
        for (int t = 0; t < 400; t++) begin
            if (t % 10 == 0) begin
                pipe0_addr_i = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
                shared_hi_i = $urandom;
                pipe_lsb_i = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
            end
            aw_sel_i = 2'($urandom);
            pipe_en_i = ($urandom % 4 == 0) ? 6'($urandom) : 6'h3F;
            if ($urandom % 4 == 0)
                frame_check("R2 rand miss", {$urandom, $urandom} & 40'hFF_FFFF_FFFF, $urandom % 2);
            else
                frame_check("R1 rand hit", ref_of($urandom % 6), $urandom % 2);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule